// File: doc/BRIEF.md
# Packed 9-bit Symbol Error Corrector

This block repairs a 512-byte sector that sits in an external byte RAM once a separate decoder has located the damaged symbols. The sector is viewed as a run of 9-bit symbols. The symbols are packed from the least significant bit upward, so most symbols cross a byte boundary. For each job the block receives a decoder status word and a fixed set of report slots. Each report names one symbol by its 1-based position and gives a 9-bit flip pattern. The block finds the two bytes that hold that symbol, reads them, XORs the pattern into the right bit field and writes both bytes back.

Jobs start with a one-cycle `start` pulse, which the block accepts only while idle. The status word and all report slots are captured on that edge. Reports are applied one after another over a separate RAM read port and RAM write port, and the read port has one cycle of latency. At the end the block raises `done` for one cycle. With it come the number of reports actually applied and a failure flag for sectors the decoder marked as beyond repair.

Top module: `sym_corrector`

## Requirements
- R1: Out of reset and whenever idle, `busy`, `done`, `ram_rd_en` and `ram_wr_en` are low.
- R2: Status fields: report count in bits 31:29, uncorrectable flag in bit 1, error flag in bit 0. No other status bit has any effect. A `start` seen while `busy` is high is ignored.
- R3: If the error flag is clear, `done` rises one cycle after `start` with `corr_count` 0 and `fail` low, and the RAM is not accessed.
- R4: If the error flag and the uncorrectable flag are both set, `done` rises one cycle after `start` with `fail` high and `corr_count` 0, and the RAM is not accessed.
- R5: Only the first min(count, NUM_REPORTS) slots are used, in slot order 0 upward. `corr_count` never exceeds NUM_REPORTS.
- R6: A report word has the symbol position in bits 24:16 and the flip pattern in bits 8:0. Position 0 marks an invalid report: it is skipped and not counted.
- R7: With index = position − 1, the low byte address is index + (index >> 3) and the bit offset is index & 7. The bytes at that address and the next one form a little-endian 16-bit pair. The pattern, shifted left by the offset, is XORed into the pair.
- R8: A report whose low byte address lies beyond the last sector byte is skipped and not counted. If the low byte is the last byte, only that byte is read and written, and pattern bits above it are dropped. The report is still counted.
- R9: Reports are applied strictly in sequence, so a report sees the bytes already written by the earlier reports of the same job. The same report given twice restores the data.
- R10: `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` is high, and it is low in the following cycle.
- R11: The RAM read data arrives one cycle after `ram_rd_en`. Reads and writes never share a cycle. The upper byte is written in the cycle right after the lower byte, at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a job; honoured only while idle |
| status | input | 32 | Decoder status word |
| reports | input | NUM_REPORTS×32 | Report slots, slot 0 in the low word |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job strobe |
| fail | output | 1 | Uncorrectable sector, valid with `done` |
| corr_count | output | clog2(NUM_REPORTS+1) | Reports applied, valid with `done` |
| ram_rd_en | output | 1 | RAM read request |
| ram_rd_addr | output | clog2(SECTOR_BYTES) | RAM read byte address |
| ram_rd_data | input | 8 | RAM read data, one cycle after the request |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | clog2(SECTOR_BYTES) | RAM write byte address |
| ram_wr_data | output | 8 | RAM write data |

## Verification
Two functions can meet on the same byte. One is the write-back of a report's upper byte. The other is the read of the next report's lower byte when the two symbols are neighbours, such as indices 8 and 9, which share byte 10. A job also repeats a symbol with the same pattern, and a near-exhaustive sweep places a single report on every position, including the last-byte and beyond-sector cases. After every job, every byte of the RAM is compared against a bench model that applies the reports in order with plain arithmetic.

// File: rtl/sym_corr_pkg.sv
package sym_corr_pkg;

  localparam int SYM_W     = 9;
  localparam int POS_W     = 9;
  localparam int POS_LSB   = 16;
  localparam int MASK_LSB  = 0;
  localparam int OFF_W     = 3;
  localparam int PAIR_W    = 16;
  localparam int CNT_MSB   = 31;
  localparam int CNT_LSB   = 29;
  localparam int UNCOR_BIT = 1;
  localparam int ERR_BIT   = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RD_LO,
    ST_RD_HI,
    ST_MERGE,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN
  } corr_state_e;

  typedef struct packed {
    logic             hit;
    logic             pair_ok;
    logic [POS_W:0]   addr;
    logic [OFF_W-1:0] off;
    logic [SYM_W-1:0] mask;
  } loc_t;

endpackage

// File: rtl/sym_corr_rst_sync.sv
module sym_corr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sym_corr_locate.sv
module sym_corr_locate
  import sym_corr_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [31:0] word,
  output loc_t        loc
);

  localparam logic [POS_W:0] LAST = (POS_W+1)'(SECTOR_BYTES - 1);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] idx;
  logic [POS_W:0]   addr_ext;
  logic             unused_bits;

  always_comb begin
    pos      = word[POS_LSB +: POS_W];
    idx      = pos - POS_W'(1);
    addr_ext = {1'b0, idx} + {{(OFF_W+1){1'b0}}, idx[POS_W-1:OFF_W]};

    loc.hit     = (pos != '0) && (addr_ext <= LAST);
    loc.pair_ok = (addr_ext < LAST);
    loc.addr    = addr_ext;
    loc.off     = idx[OFF_W-1:0];
    loc.mask    = word[MASK_LSB +: SYM_W];
  end

  assign unused_bits = ^{word[31:POS_LSB+POS_W], word[POS_LSB-1:MASK_LSB+SYM_W]};

endmodule

// File: rtl/sym_corr_merge.sv
module sym_corr_merge
  import sym_corr_pkg::*;
(
  input  logic [7:0]        lo,
  input  logic [7:0]        hi,
  input  logic [SYM_W-1:0]  mask,
  input  logic [OFF_W-1:0]  off,
  output logic [PAIR_W-1:0] pair
);

  logic [PAIR_W-1:0] flip;

  always_comb begin
    flip = {{(PAIR_W-SYM_W){1'b0}}, mask} << off;
    pair = {hi, lo} ^ flip;
  end

endmodule

// File: rtl/sym_corrector.sv
module sym_corrector
  import sym_corr_pkg::*;
#(
  parameter  int SECTOR_BYTES = 512,
  parameter  int NUM_REPORTS  = 4,
  localparam int ADDR_W       = $clog2(SECTOR_BYTES),
  localparam int CNT_W        = $clog2(NUM_REPORTS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [31:0]                   status,
  input  logic [NUM_REPORTS-1:0][31:0]  reports,
  output logic                          busy,
  output logic                          done,
  output logic                          fail,
  output logic [CNT_W-1:0]              corr_count,
  output logic                          ram_rd_en,
  output logic [ADDR_W-1:0]             ram_rd_addr,
  input  logic [7:0]                    ram_rd_data,
  output logic                          ram_wr_en,
  output logic [ADDR_W-1:0]             ram_wr_addr,
  output logic [7:0]                    ram_wr_data
);

  logic rst_sync_n;

  corr_state_e      state_q, state_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             fail_q, fail_d;
  logic [31:0]      rep_q [NUM_REPORTS];
  logic             cap_en, lo_en, hi_en;
  logic [7:0]       lo_q, hi_q, hi_in;
  logic [31:0]      cur_word;
  loc_t             loc;
  logic [PAIR_W-1:0] merged;
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic [2:0]        cnt_field;
  logic              err_flag, uncor_flag;
  logic              unused_top;

  sym_corr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // report slots captured on an accepted start
  for (genvar g = 0; g < NUM_REPORTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  rep_q[g] <= '0;
      else if (cap_en)  rep_q[g] <= reports[g];
    end
  end

  always_comb begin
    cur_word = '0;
    for (int k = 0; k < NUM_REPORTS; k++) begin
      if (ptr_q == CNT_W'(k)) cur_word = rep_q[k];
    end
  end

  sym_corr_locate #(.SECTOR_BYTES(SECTOR_BYTES)) u_locate (
    .word (cur_word),
    .loc  (loc)
  );

  sym_corr_merge u_merge (
    .lo   (lo_q),
    .hi   (hi_q),
    .mask (loc.mask),
    .off  (loc.off),
    .pair (merged)
  );

  assign lo_addr    = loc.addr[ADDR_W-1:0];
  assign hi_addr    = lo_addr + ADDR_W'(1);
  assign hi_in      = loc.pair_ok ? ram_rd_data : 8'h00;
  assign cnt_field  = status[CNT_MSB:CNT_LSB];
  assign err_flag   = status[ERR_BIT];
  assign uncor_flag = status[UNCOR_BIT];
  assign unused_top = ^{status[CNT_LSB-1:UNCOR_BIT+1], loc.addr[POS_W:ADDR_W]};

  // next-state and output decode
  always_comb begin
    state_d     = state_q;
    ptr_d       = ptr_q;
    total_d     = total_q;
    count_d     = count_q;
    fail_d      = fail_q;
    cap_en      = 1'b0;
    lo_en       = 1'b0;
    hi_en       = 1'b0;
    ram_rd_en   = 1'b0;
    ram_rd_addr = lo_addr;
    ram_wr_en   = 1'b0;
    ram_wr_addr = lo_addr;
    ram_wr_data = merged[7:0];

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          count_d = '0;
          ptr_d   = '0;
          if (!err_flag || uncor_flag) begin
            fail_d  = err_flag & uncor_flag;
            state_d = ST_FIN;
          end else begin
            fail_d  = 1'b0;
            total_d = (int'(cnt_field) > NUM_REPORTS) ? CNT_W'(NUM_REPORTS)
                                                      : CNT_W'(cnt_field);
            state_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (ptr_q >= total_q)  state_d = ST_FIN;
        else if (!loc.hit)     ptr_d   = ptr_q + CNT_W'(1);
        else                   state_d = ST_RD_LO;
      end
      ST_RD_LO: begin
        ram_rd_en = 1'b1;
        state_d   = ST_RD_HI;
      end
      ST_RD_HI: begin
        ram_rd_en   = loc.pair_ok;
        ram_rd_addr = hi_addr;
        lo_en       = 1'b1;
        state_d     = ST_MERGE;
      end
      ST_MERGE: begin
        hi_en   = 1'b1;
        state_d = ST_WR_LO;
      end
      ST_WR_LO: begin
        ram_wr_en = 1'b1;
        if (loc.pair_ok) begin
          state_d = ST_WR_HI;
        end else begin
          count_d = count_q + CNT_W'(1);
          ptr_d   = ptr_q + CNT_W'(1);
          state_d = ST_SCAN;
        end
      end
      ST_WR_HI: begin
        ram_wr_en   = 1'b1;
        ram_wr_addr = hi_addr;
        ram_wr_data = merged[15:8];
        count_d     = count_q + CNT_W'(1);
        ptr_d       = ptr_q + CNT_W'(1);
        state_d     = ST_SCAN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      total_q <= '0;
      count_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      total_q <= total_d;
      count_q <= count_d;
      fail_q  <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_en) lo_q <= ram_rd_data;
      if (hi_en) hi_q <= hi_in;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign fail       = fail_q;
  assign corr_count = count_q;

endmodule

// File: rtl/sym_corrector_chk.sv
module sym_corrector_chk #(
  parameter int NUM_REPORTS = 4,
  parameter int CNT_W       = 3,
  parameter int ADDR_W      = 9
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              start,
  input logic              err_flag,
  input logic              uncor_flag,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  corr_count,
  input logic              ram_rd_en,
  input logic              ram_wr_en,
  input logic [ADDR_W-1:0] ram_wr_addr
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!ram_rd_en && !ram_wr_en && !done));

  assert_clean_exit_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start && !err_flag) |=> (done && !fail && corr_count == '0));

  assert_uncor_exit_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start && err_flag && uncor_flag) |=> (done && fail && corr_count == '0));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (int'(corr_count) <= NUM_REPORTS));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ram_rd_en && ram_wr_en));

  assert_write_pair_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_wr_en && $past(ram_wr_en)) |-> (ram_wr_addr == $past(ram_wr_addr) + ADDR_W'(1)));

endmodule

bind sym_corrector sym_corrector_chk #(
  .NUM_REPORTS (NUM_REPORTS),
  .CNT_W       (CNT_W),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .start       (start),
  .err_flag    (status[0]),
  .uncor_flag  (status[1]),
  .busy        (busy),
  .done        (done),
  .fail        (fail),
  .corr_count  (corr_count),
  .ram_rd_en   (ram_rd_en),
  .ram_wr_en   (ram_wr_en),
  .ram_wr_addr (ram_wr_addr)
);

// File: tb/sym_corrector_tb.sv
module sym_corrector_tb;

  localparam int NR = 4;
  localparam int SB = 512;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [31:0]       status;
  logic [NR-1:0][31:0] reps;
  logic              busy, done, fail;
  logic [2:0]        corr_count;
  logic              rd_en, wr_en;
  logic [8:0]        rd_addr, wr_addr;
  logic [7:0]        rd_data, wr_data;

  int tests, fails, acc, viol, cyc;
  logic       prev_wr;
  logic [8:0] prev_addr;
  logic [7:0] ram [SB];
  int         ref_mem [SB];

  sym_corrector #(.SECTOR_BYTES(SB), .NUM_REPORTS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .status(status), .reports(reps),
    .busy(busy), .done(done), .fail(fail), .corr_count(corr_count),
    .ram_rd_en(rd_en), .ram_rd_addr(rd_addr), .ram_rd_data(rd_data),
    .ram_wr_en(wr_en), .ram_wr_addr(wr_addr), .ram_wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // byte RAM: one-cycle read latency, read before write
  always @(posedge clk) begin
    if (rd_en) rd_data <= ram[rd_addr];
    if (wr_en) ram[wr_addr] = wr_data;
  end

  // port activity monitor
  always @(negedge clk) begin
    if (rd_en || wr_en) acc++;
    if (rd_en && wr_en) viol++;
    if (wr_en && prev_wr && wr_addr != prev_addr + 9'd1) viol++;
    prev_wr   = wr_en;
    prev_addr = wr_addr;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog expired: actual %0d cycles, expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_apply(input logic [31:0] w, output int applied);
    int pos, idx, a, off, m, pair;
    applied = 0;
    pos = int'(w[24:16]);
    if (pos == 0) return;
    idx = pos - 1;
    a   = idx + idx / 8;
    if (a > SB - 1) return;
    off  = idx % 8;
    m    = int'(w[8:0]);
    pair = ref_mem[a] + ((a < SB - 1) ? ref_mem[a+1] * 256 : 0);
    pair = pair ^ (m << off);
    ref_mem[a] = pair & 255;
    if (a < SB - 1) ref_mem[a+1] = (pair >> 8) & 255;
    applied = 1;
  endtask

  task automatic cmp_mem(input string req);
    int bad, first;
    bad = 0;
    first = -1;
    for (int a = 0; a < SB; a++) begin
      if (int'(ram[a]) != ref_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " sector byte at first mismatch"}, int'(ram[first]), ref_mem[first]);
  endtask

  // one job with expected values from the requirements
  task automatic job(input logic [31:0] st, input logic [NR-1:0][31:0] r, input string req);
    int exp_cnt, n, app, waitc;
    bit early, exp_fail;
    early    = !st[0] || st[1];
    exp_fail = st[0] && st[1];
    exp_cnt  = 0;
    if (!early) begin
      n = (int'(st[31:29]) > NR) ? NR : int'(st[31:29]);
      for (int k = 0; k < n; k++) begin
        ref_apply(r[k], app);
        exp_cnt += app;
      end
    end
    @(negedge clk);
    start  = 1'b1;
    status = st;
    reps   = r;
    acc    = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (early) chk(done == 1'b1, "R3/R4 done one cycle after start: R3", int'(done), 1);
    waitc = 0;
    while (!done && waitc < 100) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == 1'b1, {req, " done seen"}, int'(done), 1);
    chk(int'(corr_count) == exp_cnt, {req, " corr_count"}, int'(corr_count), exp_cnt);
    chk(fail == exp_fail, {req, " fail R4"}, int'(fail), int'(exp_fail));
    if (early) chk(acc == 0, {req, " RAM untouched R3"}, acc, 0);
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle then idle", int'({done, busy}), 0);
    cmp_mem(req);
  endtask

  function automatic logic [31:0] rw(input int pos, input int mask);
    return {7'd0, 9'(pos), 7'd0, 9'(mask)};
  endfunction

  initial begin
    logic [NR-1:0][31:0] r;
    int c0, waitc;
    tests = 0; fails = 0; acc = 0; viol = 0; cyc = 0;
    prev_wr = 1'b0; prev_addr = '0;
    rst_n = 1'b0; start = 1'b0; status = '0; reps = '0;
    for (int a = 0; a < SB; a++) begin
      ram[a]     = 8'((a * 29 + 17) & 255);
      ref_mem[a] = (a * 29 + 17) & 255;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!busy && !done && !rd_en && !wr_en, "R1 idle after reset",
        int'({busy, done, rd_en, wr_en}), 0);

    // R3: error flag clear, reports present
    r = {rw(40, 9'h1ff), rw(30, 9'h0aa), rw(20, 9'h155), rw(10, 9'h001)};
    job({3'd4, 27'd0, 2'b00}, r, "R3 clean status");
    job({3'd4, 27'd0, 2'b10}, r, "R3 uncorrectable without error flag");
    // R4
    job({3'd4, 27'd0, 2'b11}, r, "R4 uncorrectable");

    // R6 R7 R8 sweep of every position, one report, other slots inert
    for (int p = 0; p < 512; p++) begin
      r = {rw(3, 9'h1ff), rw(200, 9'h0f0), rw(77, 9'h00f), rw(p, ((p * 37 + 91) & 9'h1ff) | 1)};
      job({3'd1, 27'd0, 2'b01}, r, "R7 position sweep R6 R8 R5");
    end

    // R9 neighbours sharing byte 10, and repeated symbol
    r = {rw(9, 9'h101), rw(11, 9'h0ff), rw(10, 9'h1a5), rw(9, 9'h13c)};
    job({3'd4, 27'd0, 2'b01}, r, "R9 neighbour symbols");
    r = {rw(100, 9'h0c3), rw(100, 9'h0c3), rw(456, 9'h1ff), rw(456, 9'h1ff)};
    job({3'd4, 27'd0, 2'b01}, r, "R9 repeated symbol");

    // R8 mixed skips: position 0, beyond sector, last byte
    r = {rw(1, 9'h1ff), rw(456, 9'h1c7), rw(500, 9'h0ff), rw(0, 9'h1ff)};
    job({3'd4, 27'd0, 2'b01}, r, "R8 mixed skips");

    // R2 R5 count field sweep with unrelated status bits set
    for (int c = 0; c < 8; c++) begin
      r = {rw(300 + c, 9'h111), rw(64 + c, 9'h022), rw(17 + c, 9'h144), rw(5 + c, 9'h088)};
      job({3'(c), 27'h7ff_fff8 >> 1, 2'b01}, r, "R5 count field R2");
    end

    // R2 start while busy is ignored
    r = {rw(0, 0), rw(0, 0), rw(50, 9'h0f1), rw(250, 9'h11e)};
    begin
      int a1, a2;
      ref_apply(r[0], a1);
      ref_apply(r[1], a2);
      c0 = a1 + a2;
    end
    @(negedge clk);
    start = 1'b1; status = {3'd2, 27'd0, 2'b01}; reps = r;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; status = 32'h0; reps = '0;
    @(negedge clk);
    start = 1'b0;
    waitc = 0;
    while (!done && waitc < 100) begin
      @(negedge clk);
      waitc++;
    end
    chk(int'(corr_count) == c0 && !fail, "R2 start during busy ignored", int'(corr_count), c0);
    repeat (4) begin
      @(negedge clk);
      chk(!done && !busy, "R2 no second job", int'({done, busy}), 0);
    end
    cmp_mem("R2 sector after ignored start");

    // R11 port sequencing seen by the monitor
    chk(viol == 0, "R11 read/write sequencing", viol, 0);

    summary();
    $finish;
  end

endmodule